// File: doc/BRIEF.md
# Bus Address Map Translator

This block turns addresses issued by masters on an 18-bit peripheral bus into 30-bit system memory addresses. The bus address space is split into 512-byte pages. Each page has its own map entry. An entry carries a valid flag, a data-path selector, an odd-byte flag and a page frame number. Software fills the map through a 32-bit register port. The same port also exposes a fixed identification word, three inert data-path slots and a control/status word. Eight longword slots in that port are handed on to a neighbouring sub-device rather than being decoded here.

A separate lookup port accepts one bus address per cycle. One cycle later it returns either a physical address or a miss. A miss has three causes:
- the page has no map entry;
- the entry is not marked valid;
- the translated address would land above the configured top of memory.

A translation refused for the last reason raises a sticky flag in the control/status word. Software clears that flag by writing to the word.

Top module: `addr_xlt`

## Requirements
- R1: Longword offset 0 (byte address 0x000) always reads 0x0000_0028, and a write to it changes nothing that a later read can see.
- R2: Longword offsets 1, 2 and 3 (byte addresses 0x004 to 0x00C) read as zero, and writes to them have no visible effect.
- R3: The control/status word is at byte address 0x010. Its bit 16 is set by a lookup that is refused only because of the memory-top limit. A register write with data bit 16 set clears the whole word, and a write without bit 16 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R4: Map entry i lives at byte address 0x800 + 4*i. A write keeps only the bits under 0x87FF_FFFF: valid (31), longword enable (26), odd byte (25), data path (24:21) and page frame (20:0). A read returns exactly that masked value.
- R5: A legal access to a map index of 496 or more, to longword offsets 5 to 0x7F, or to 0x88 to 0x1FF is acknowledged with the nonexistent-register flag set and read data zero.
- R6: An access whose byte address is not a multiple of four, or whose size code is not 2 (size codes: 0 byte, 1 word, 2 longword), gets no acknowledge, is not forwarded and changes no state.
- R7: A legal access to longword offsets 0x80 to 0x87 (byte addresses 0x200 to 0x21C) drives the forward strobe in the same cycle, with slot number offset minus 0x80, the write flag and the write data. It gets no acknowledge from this block.
- R8: A lookup misses when its page number (bus address bits 17:9) is 496 or more, or when the entry's valid bit is clear. On a miss the returned address is zero.
- R9: On a hit, the returned address is the page frame times 512 plus bus address bits 8:0.
- R10: One is added to the hit address when the data-path field is nonzero and the odd-byte bit is set. Neither field alone changes the address.
- R11: A lookup whose final address, including the odd-byte increment, exceeds MEM_TOP (default 0x00FF_FFFF) misses.
- R12: Reset clears every map entry and the control/status word, and drives every registered output to zero.
- R13: Register responses and lookup results appear exactly one clock after the request, as one-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_req | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address within the register window |
| reg_size | input | 2 | Access size code: 0 byte, 1 word, 2 longword |
| reg_wdata | input | 32 | Write data |
| reg_ack | output | 1 | Response pulse for a decoded access |
| reg_nxm | output | 1 | Response is for a nonexistent register |
| reg_rdata | output | 32 | Read data, valid with reg_ack |
| fwd_req | output | 1 | Access forwarded to the sub-device |
| fwd_wr | output | 1 | Forwarded access is a write |
| fwd_idx | output | 3 | Forwarded longword slot |
| fwd_wdata | output | 32 | Forwarded write data |
| xl_req | input | 1 | Lookup strobe |
| xl_addr | input | 18 | Bus address to translate |
| xl_ack | output | 1 | Lookup result pulse |
| xl_hit | output | 1 | Translation succeeded |
| xl_pa | output | 30 | Physical address, zero on a miss |

## Verification
The state that is hardest to reach from the ports is the memory-top boundary. There, the odd-byte increment alone carries a legal in-page address one byte past the limit, so the same page hits at one offset and misses at the next. The stimulus programs a page whose frame ends exactly at the top of memory and sets both the data-path and odd-byte fields. It then looks up the two last offsets of that page. Between lookups it reads the control/status word, to show that only the refused lookup raised the sticky flag. It then clears the flag with writes that do and do not carry bit 16.

// File: rtl/addr_xlt_pkg.sv
package addr_xlt_pkg;

  localparam logic [31:0] ID_WORD   = 32'h0000_0028;
  localparam logic [31:0] MAP_KEEP  = 32'h87FF_FFFF;
  localparam int unsigned FLAG_BIT  = 16;
  localparam int unsigned FRAME_W   = 21;
  localparam int unsigned DPATH_W   = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    WIN_IGNORE,
    WIN_ID,
    WIN_DPATH,
    WIN_CTRL,
    WIN_MAP,
    WIN_FWD,
    WIN_NXM
  } win_e;

  // Stored map entry: only the bits that survive the write mask.
  typedef struct packed {
    logic               valid;
    logic               lw_en;
    logic               odd;
    logic [DPATH_W-1:0] dpath;
    logic [FRAME_W-1:0] frame;
  } map_ent_t;

  // Fields the translation path needs.
  typedef struct packed {
    logic               valid;
    logic               odd;
    logic [DPATH_W-1:0] dpath;
    logic [FRAME_W-1:0] frame;
  } xl_ent_t;

  function automatic map_ent_t word_to_ent(input logic [31:0] w);
    map_ent_t e;
    logic [31:0] m;
    m       = w & MAP_KEEP;
    e.valid = m[31];
    e.lw_en = m[26];
    e.odd   = m[25];
    e.dpath = m[24:21];
    e.frame = m[20:0];
    return e;
  endfunction

  function automatic logic [31:0] ent_to_word(input map_ent_t e);
    return {e.valid, 4'b0000, e.lw_en, e.odd, e.dpath, e.frame};
  endfunction

endpackage

// File: rtl/addr_xlt_regdec.sv
module addr_xlt_regdec
  import addr_xlt_pkg::*;
#(
  parameter int unsigned REG_AW   = 12,
  parameter int unsigned NUM_MAP  = 496,
  parameter int unsigned MAP_BASE = 'h200,
  parameter int unsigned FWD_BASE = 'h80,
  parameter int unsigned FWD_LEN  = 8,
  localparam int unsigned OFS_W   = REG_AW - 2,
  localparam int unsigned IDX_W   = $clog2(NUM_MAP),
  localparam int unsigned FWD_IW  = $clog2(FWD_LEN)
) (
  input  logic              req,
  input  logic [REG_AW-1:0] addr,
  input  logic [1:0]        size,
  output win_e              win,
  output logic [IDX_W-1:0]  map_idx,
  output logic [FWD_IW-1:0] fwd_idx
);

  localparam int unsigned CTRL_OFS  = 4;
  localparam int unsigned DP_FIRST  = 1;
  localparam int unsigned DP_LAST   = 3;

  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] map_off;
  logic [OFS_W-1:0] fwd_off;
  logic             legal;

  assign ofs     = addr[REG_AW-1:2];
  assign map_off = ofs - OFS_W'(MAP_BASE);
  assign fwd_off = ofs - OFS_W'(FWD_BASE);
  assign legal   = (size == SZ_LONG) && (addr[1:0] == 2'b00);

  always_comb begin
    win     = WIN_IGNORE;
    map_idx = '0;
    fwd_idx = '0;
    if (req && legal) begin
      if (32'(ofs) >= MAP_BASE) begin
        if (32'(map_off) < NUM_MAP) begin
          win     = WIN_MAP;
          map_idx = map_off[IDX_W-1:0];
        end else begin
          win = WIN_NXM;
        end
      end else if (32'(ofs) >= FWD_BASE) begin
        if (32'(fwd_off) < FWD_LEN) begin
          win     = WIN_FWD;
          fwd_idx = fwd_off[FWD_IW-1:0];
        end else begin
          win = WIN_NXM;
        end
      end else if (ofs == '0) begin
        win = WIN_ID;
      end else if (32'(ofs) >= DP_FIRST && 32'(ofs) <= DP_LAST) begin
        win = WIN_DPATH;
      end else if (32'(ofs) == CTRL_OFS) begin
        win = WIN_CTRL;
      end else begin
        win = WIN_NXM;
      end
    end
  end

endmodule

// File: rtl/addr_xlt_mapfile.sv
module addr_xlt_mapfile
  import addr_xlt_pkg::*;
#(
  parameter int unsigned NUM_MAP = 496,
  localparam int unsigned IDX_W  = $clog2(NUM_MAP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  map_ent_t         wdata,
  input  logic [IDX_W-1:0] ridx,
  output map_ent_t         rdata,
  input  logic [IDX_W-1:0] lidx,
  input  logic             lidx_ok,
  output xl_ent_t          ldata
);

  map_ent_t ent_all [NUM_MAP];

  for (genvar g = 0; g < NUM_MAP; g++) begin : g_ent
    logic     en;
    map_ent_t q;
    assign en = we && (widx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= wdata;
      end
    end
    assign ent_all[g] = q;
  end

  map_ent_t lsel;

  always_comb begin
    rdata = '0;
    if (32'(ridx) < NUM_MAP) begin
      rdata = ent_all[ridx];
    end
    lsel = '0;
    if (lidx_ok && (32'(lidx) < NUM_MAP)) begin
      lsel = ent_all[lidx];
    end
    ldata.valid = lsel.valid;
    ldata.odd   = lsel.odd;
    ldata.dpath = lsel.dpath;
    ldata.frame = lsel.frame;
  end

endmodule

// File: rtl/addr_xlt_lookup.sv
module addr_xlt_lookup
  import addr_xlt_pkg::*;
#(
  parameter int unsigned BUS_AW     = 18,
  parameter int unsigned PAGE_SHIFT = 9,
  parameter int unsigned NUM_MAP    = 496,
  parameter int unsigned PA_W       = 30,
  parameter logic [31:0] MEM_TOP    = 32'h00FF_FFFF,
  localparam int unsigned PG_W      = BUS_AW - PAGE_SHIFT,
  localparam int unsigned SUM_W     = PA_W + 1
) (
  input  logic [BUS_AW-1:0] bus_addr,
  output logic [PG_W-1:0]   page,
  output logic              page_ok,
  input  xl_ent_t           ent,
  output logic              hit,
  output logic              top_fail,
  output logic [PA_W-1:0]   pa
);

  logic [SUM_W-1:0] base;
  logic [SUM_W-1:0] sum;
  logic             bump;
  logic             over;

  assign page    = bus_addr[BUS_AW-1:PAGE_SHIFT];
  assign page_ok = 32'(page) < NUM_MAP;

  always_comb begin
    base     = SUM_W'({ent.frame, bus_addr[PAGE_SHIFT-1:0]});
    bump     = (ent.dpath != '0) && ent.odd;
    sum      = base + SUM_W'(bump);
    over     = sum > SUM_W'(MEM_TOP);
    hit      = page_ok && ent.valid && !over;
    top_fail = page_ok && ent.valid && over;
    pa       = hit ? sum[PA_W-1:0] : '0;
  end

endmodule

// File: rtl/addr_xlt.sv
module addr_xlt
  import addr_xlt_pkg::*;
#(
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned NUM_MAP    = 496,
  parameter int unsigned BUS_AW     = 18,
  parameter int unsigned PAGE_SHIFT = 9,
  parameter int unsigned PA_W       = 30,
  parameter logic [31:0] MEM_TOP    = 32'h00FF_FFFF,
  parameter int unsigned FWD_LEN    = 8,
  localparam int unsigned IDX_W     = $clog2(NUM_MAP),
  localparam int unsigned FWD_IW    = $clog2(FWD_LEN),
  localparam int unsigned PG_W      = BUS_AW - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic              reg_ack,
  output logic              reg_nxm,
  output logic [31:0]       reg_rdata,
  output logic              fwd_req,
  output logic              fwd_wr,
  output logic [FWD_IW-1:0] fwd_idx,
  output logic [31:0]       fwd_wdata,
  input  logic              xl_req,
  input  logic [BUS_AW-1:0] xl_addr,
  output logic              xl_ack,
  output logic              xl_hit,
  output logic [PA_W-1:0]   xl_pa
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // Register window decode.
  win_e              win;
  logic [IDX_W-1:0]  map_idx;
  logic [FWD_IW-1:0] fwd_slot;

  addr_xlt_regdec #(
    .REG_AW (REG_AW),
    .NUM_MAP(NUM_MAP),
    .FWD_LEN(FWD_LEN)
  ) u_dec (
    .req    (reg_req),
    .addr   (reg_addr),
    .size   (reg_size),
    .win    (win),
    .map_idx(map_idx),
    .fwd_idx(fwd_slot)
  );

  // Translation.
  logic [PG_W-1:0] page;
  logic            page_ok;
  xl_ent_t         xl_ent;
  logic            lk_hit;
  logic            lk_top_fail;
  logic [PA_W-1:0] lk_pa;

  addr_xlt_lookup #(
    .BUS_AW    (BUS_AW),
    .PAGE_SHIFT(PAGE_SHIFT),
    .NUM_MAP   (NUM_MAP),
    .PA_W      (PA_W),
    .MEM_TOP   (MEM_TOP)
  ) u_look (
    .bus_addr(xl_addr),
    .page    (page),
    .page_ok (page_ok),
    .ent     (xl_ent),
    .hit     (lk_hit),
    .top_fail(lk_top_fail),
    .pa      (lk_pa)
  );

  // Map storage.
  logic     map_we;
  map_ent_t map_went;
  map_ent_t map_rent;

  assign map_we   = (win == WIN_MAP) && reg_wr;
  assign map_went = word_to_ent(reg_wdata);

  addr_xlt_mapfile #(
    .NUM_MAP(NUM_MAP)
  ) u_map (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (map_we),
    .widx   (map_idx),
    .wdata  (map_went),
    .ridx   (map_idx),
    .rdata  (map_rent),
    .lidx   (page[IDX_W-1:0]),
    .lidx_ok(page_ok),
    .ldata  (xl_ent)
  );

  // Forwarded sub-window, combinational pass-through.
  assign fwd_req   = (win == WIN_FWD);
  assign fwd_wr    = fwd_req && reg_wr;
  assign fwd_idx   = fwd_slot;
  assign fwd_wdata = reg_wdata;

  // Next-state logic.
  logic [31:0]     csr_q;
  logic [31:0]     csr_d;
  logic            csr_en;
  logic            ack_d;
  logic            nxm_d;
  logic [31:0]     rdata_d;
  logic            xack_d;
  logic            xhit_d;
  logic [PA_W-1:0] xpa_d;

  always_comb begin
    ack_d   = (win == WIN_ID) || (win == WIN_DPATH) || (win == WIN_CTRL) ||
              (win == WIN_MAP) || (win == WIN_NXM);
    nxm_d   = (win == WIN_NXM);
    rdata_d = '0;
    if (!reg_wr) begin
      case (win)
        WIN_ID:   rdata_d = ID_WORD;
        WIN_CTRL: rdata_d = csr_q;
        WIN_MAP:  rdata_d = ent_to_word(map_rent);
        default:  rdata_d = '0;
      endcase
    end

    csr_d = csr_q;
    if ((win == WIN_CTRL) && reg_wr && reg_wdata[FLAG_BIT]) begin
      csr_d = '0;
    end
    if (xl_req && lk_top_fail) begin
      csr_d[FLAG_BIT] = 1'b1;
    end
    csr_en = (csr_d != csr_q);

    xack_d = xl_req;
    xhit_d = xl_req && lk_hit;
    xpa_d  = xl_req ? lk_pa : '0;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      csr_q <= '0;
    end else if (csr_en) begin
      csr_q <= csr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      reg_ack   <= 1'b0;
      reg_nxm   <= 1'b0;
      reg_rdata <= '0;
      xl_ack    <= 1'b0;
      xl_hit    <= 1'b0;
      xl_pa     <= '0;
    end else begin
      reg_ack   <= ack_d;
      reg_nxm   <= nxm_d;
      reg_rdata <= rdata_d;
      xl_ack    <= xack_d;
      xl_hit    <= xhit_d;
      xl_pa     <= xpa_d;
    end
  end

endmodule

// File: rtl/addr_xlt_chk.sv
module addr_xlt_chk #(
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned NUM_MAP    = 496,
  parameter int unsigned BUS_AW     = 18,
  parameter int unsigned PAGE_SHIFT = 9,
  parameter int unsigned PA_W       = 30,
  parameter logic [31:0] MEM_TOP    = 32'h00FF_FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [1:0]        reg_size,
  input logic [31:0]       reg_wdata,
  input logic              reg_ack,
  input logic              reg_nxm,
  input logic              fwd_req,
  input logic              xl_req,
  input logic [BUS_AW-1:0] xl_addr,
  input logic              xl_ack,
  input logic              xl_hit,
  input logic [PA_W-1:0]   xl_pa,
  input logic [31:0]       csr_q
);

  a_r13_reg_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack |-> $past(reg_req));

  a_r13_xl_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    xl_ack |-> $past(xl_req));

  a_r6_bad_access_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && (reg_size != 2'd2 || reg_addr[1:0] != 2'b00)) |=> !reg_ack);

  a_r6_fwd_needs_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_req |-> (reg_req && reg_size == 2'd2 && reg_addr[1:0] == 2'b00));

  a_r7_fwd_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_req |-> (reg_addr >= REG_AW'('h200) && reg_addr <= REG_AW'('h21C)));

  a_r5_nxm_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_nxm |-> reg_ack);

  a_r8_hit_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    xl_hit |-> xl_ack);

  a_r8_miss_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_ack && !xl_hit) |-> (xl_pa == '0));

  a_r8_beyond_map_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && (32'(xl_addr[BUS_AW-1:PAGE_SHIFT]) >= NUM_MAP)) |=> !xl_hit);

  a_r11_pa_under_top: assert property (@(posedge clk) disable iff (!rst_n)
    xl_hit |-> (32'(xl_pa) <= MEM_TOP));

  a_r3_clear_on_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_wr && reg_size == 2'd2 && reg_addr == REG_AW'('h010) &&
     reg_wdata[16] && !xl_req) |=> (csr_q == 32'h0));

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!xl_req && !(reg_req && reg_wr)) |=> $stable(csr_q));

endmodule

bind addr_xlt addr_xlt_chk #(
  .REG_AW    (REG_AW),
  .NUM_MAP   (NUM_MAP),
  .BUS_AW    (BUS_AW),
  .PAGE_SHIFT(PAGE_SHIFT),
  .PA_W      (PA_W),
  .MEM_TOP   (MEM_TOP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_req  (reg_req),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_size (reg_size),
  .reg_wdata(reg_wdata),
  .reg_ack  (reg_ack),
  .reg_nxm  (reg_nxm),
  .fwd_req  (fwd_req),
  .xl_req   (xl_req),
  .xl_addr  (xl_addr),
  .xl_ack   (xl_ack),
  .xl_hit   (xl_hit),
  .xl_pa    (xl_pa),
  .csr_q    (csr_q)
);

// File: tb/tb_addr_xlt.sv
`timescale 1ns/1ps
module tb_addr_xlt;

  logic        clk;
  logic        rst_n;
  logic        reg_req;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [1:0]  reg_size;
  logic [31:0] reg_wdata;
  logic        reg_ack;
  logic        reg_nxm;
  logic [31:0] reg_rdata;
  logic        fwd_req;
  logic        fwd_wr;
  logic [2:0]  fwd_idx;
  logic [31:0] fwd_wdata;
  logic        xl_req;
  logic [17:0] xl_addr;
  logic        xl_ack;
  logic        xl_hit;
  logic [29:0] xl_pa;

  int nchk  = 0;
  int nfail = 0;

  addr_xlt dut (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_nxm(reg_nxm), .reg_rdata(reg_rdata),
    .fwd_req(fwd_req), .fwd_wr(fwd_wr), .fwd_idx(fwd_idx), .fwd_wdata(fwd_wdata),
    .xl_req(xl_req), .xl_addr(xl_addr),
    .xl_ack(xl_ack), .xl_hit(xl_hit), .xl_pa(xl_pa)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        lk;
    logic        wr;
    logic [1:0]  sz;
    logic [17:0] addr;
    logic [31:0] data;
    logic        e_ack;
    logic        e_flag;
    logic [31:0] e_val;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 48;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd2,18'h000,32'h0,        1'b1,1'b0,32'h0000_0028,4'd1},  // R1 id read
    '{1'b0,1'b1,2'd2,18'h000,32'hFFFF_FFFF,1'b1,1'b0,32'h0,        4'd1},  // R1 write ignored
    '{1'b0,1'b0,2'd2,18'h000,32'h0,        1'b1,1'b0,32'h0000_0028,4'd1},  // R1 unchanged
    '{1'b0,1'b0,2'd2,18'h004,32'h0,        1'b1,1'b0,32'h0,        4'd2},  // R2
    '{1'b0,1'b1,2'd2,18'h008,32'hDEAD_BEEF,1'b1,1'b0,32'h0,        4'd2},  // R2
    '{1'b0,1'b0,2'd2,18'h008,32'h0,        1'b1,1'b0,32'h0,        4'd2},  // R2
    '{1'b0,1'b0,2'd2,18'h010,32'h0,        1'b1,1'b0,32'h0,        4'd12}, // R12 ctrl after reset
    '{1'b0,1'b0,2'd2,18'h804,32'h0,        1'b1,1'b0,32'h0,        4'd12}, // R12 map after reset
    '{1'b0,1'b1,2'd2,18'h800,32'hFFFF_FFFF,1'b1,1'b0,32'h0,        4'd4},  // R4
    '{1'b0,1'b0,2'd2,18'h800,32'h0,        1'b1,1'b0,32'h87FF_FFFF,4'd4},  // R4 masked
    '{1'b0,1'b1,2'd2,18'h804,32'h8000_0005,1'b1,1'b0,32'h0,        4'd4},  // R4 page1
    '{1'b0,1'b1,2'd2,18'h808,32'h8220_0010,1'b1,1'b0,32'h0,        4'd4},  // R4 page2 odd+dp
    '{1'b0,1'b1,2'd2,18'h80C,32'h0000_0007,1'b1,1'b0,32'h0,        4'd4},  // R4 page3 invalid
    '{1'b0,1'b1,2'd2,18'h810,32'h8200_0020,1'b1,1'b0,32'h0,        4'd4},  // R4 page4 odd only
    '{1'b0,1'b1,2'd2,18'h814,32'h8000_8000,1'b1,1'b0,32'h0,        4'd4},  // R4 page5 past top
    '{1'b0,1'b1,2'd2,18'h818,32'h8220_7FFF,1'b1,1'b0,32'h0,        4'd4},  // R4 page6 edge
    '{1'b0,1'b1,2'd2,18'hFBC,32'h8000_7FFF,1'b1,1'b0,32'h0,        4'd4},  // R4 page495
    '{1'b0,1'b0,2'd2,18'h808,32'h0,        1'b1,1'b0,32'h8220_0010,4'd4},  // R4 readback
    '{1'b0,1'b0,2'd2,18'hFC0,32'h0,        1'b1,1'b1,32'h0,        4'd5},  // R5 index 496
    '{1'b0,1'b1,2'd2,18'hFC0,32'h1,        1'b1,1'b1,32'h0,        4'd5},  // R5
    '{1'b0,1'b0,2'd2,18'h220,32'h0,        1'b1,1'b1,32'h0,        4'd5},  // R5 offset 0x88
    '{1'b0,1'b0,2'd2,18'h014,32'h0,        1'b1,1'b1,32'h0,        4'd5},  // R5 offset 5
    '{1'b0,1'b0,2'd2,18'h001,32'h0,        1'b0,1'b0,32'h0,        4'd6},  // R6 unaligned
    '{1'b0,1'b0,2'd1,18'h000,32'h0,        1'b0,1'b0,32'h0,        4'd6},  // R6 word size
    '{1'b0,1'b1,2'd0,18'h804,32'h0,        1'b0,1'b0,32'h0,        4'd6},  // R6 byte write
    '{1'b0,1'b1,2'd1,18'h804,32'h0,        1'b0,1'b0,32'h0,        4'd6},  // R6 word write
    '{1'b0,1'b0,2'd2,18'h804,32'h0,        1'b1,1'b0,32'h8000_0005,4'd6},  // R6 entry untouched
    '{1'b0,1'b0,2'd2,18'h200,32'h0,        1'b0,1'b0,32'h0,        4'd7},  // R7 no ack here
    '{1'b1,1'b0,2'd0,18'h00323,32'h0,      1'b1,1'b1,32'h0000_0B23,4'd9},  // R9
    '{1'b1,1'b0,2'd0,18'h00440,32'h0,      1'b1,1'b1,32'h0000_2041,4'd10}, // R10 +1
    '{1'b1,1'b0,2'd0,18'h00808,32'h0,      1'b1,1'b1,32'h0000_4008,4'd10}, // R10 odd alone
    '{1'b1,1'b0,2'd0,18'h00600,32'h0,      1'b1,1'b0,32'h0,        4'd8},  // R8 invalid
    '{1'b1,1'b0,2'd0,18'h00E00,32'h0,      1'b1,1'b0,32'h0,        4'd12}, // R12 never written
    '{1'b1,1'b0,2'd0,18'h3E000,32'h0,      1'b1,1'b0,32'h0,        4'd8},  // R8 page 496
    '{1'b1,1'b0,2'd0,18'h3FFFF,32'h0,      1'b1,1'b0,32'h0,        4'd8},  // R8 page 511
    '{1'b0,1'b0,2'd2,18'h010,32'h0,        1'b1,1'b0,32'h0,        4'd3},  // R3 still clear
    '{1'b1,1'b0,2'd0,18'h3DFFF,32'h0,      1'b1,1'b1,32'h00FF_FFFF,4'd11}, // R11 exact top
    '{1'b1,1'b0,2'd0,18'h00DFE,32'h0,      1'b1,1'b1,32'h00FF_FFFF,4'd11}, // R11 top with +1
    '{1'b0,1'b0,2'd2,18'h010,32'h0,        1'b1,1'b0,32'h0,        4'd3},  // R3 hits keep clear
    '{1'b1,1'b0,2'd0,18'h00DFF,32'h0,      1'b1,1'b0,32'h0,        4'd11}, // R11 +1 crosses top
    '{1'b0,1'b0,2'd2,18'h010,32'h0,        1'b1,1'b0,32'h0001_0000,4'd3},  // R3 flag set
    '{1'b0,1'b1,2'd2,18'h010,32'hFFFE_FFFF,1'b1,1'b0,32'h0,        4'd3},  // R3 no bit16
    '{1'b0,1'b0,2'd2,18'h010,32'h0,        1'b1,1'b0,32'h0001_0000,4'd3},  // R3 kept
    '{1'b0,1'b1,2'd2,18'h010,32'h0001_0000,1'b1,1'b0,32'h0,        4'd3},  // R3 clear
    '{1'b0,1'b0,2'd2,18'h010,32'h0,        1'b1,1'b0,32'h0,        4'd3},  // R3 cleared
    '{1'b1,1'b0,2'd0,18'h00A00,32'h0,      1'b1,1'b0,32'h0,        4'd11}, // R11 frame past top
    '{1'b1,1'b0,2'd0,18'h00000,32'h0,      1'b1,1'b0,32'h0,        4'd11}, // R11 all-ones entry
    '{1'b0,1'b0,2'd2,18'h010,32'h0,        1'b1,1'b0,32'h0001_0000,4'd3}   // R3 set again
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_req = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_size = 2'd2;
    reg_wdata = '0; xl_req = 1'b0; xl_addr = '0;
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    if (v.lk) begin
      xl_req = 1'b1; xl_addr = v.addr;
    end else begin
      reg_req = 1'b1; reg_wr = v.wr; reg_size = v.sz;
      reg_addr = v.addr[11:0]; reg_wdata = v.data;
    end
    @(negedge clk);
    idle_inputs();
    if (v.lk) begin
      chk(xl_ack == v.e_ack, int'(v.rq), "lookup ack", 32'(xl_ack), 32'(v.e_ack));
      chk(xl_hit == v.e_flag, int'(v.rq), "lookup hit", 32'(xl_hit), 32'(v.e_flag));
      chk(32'(xl_pa) == v.e_val, int'(v.rq), "lookup pa", 32'(xl_pa), v.e_val);
    end else begin
      chk(reg_ack == v.e_ack, int'(v.rq), "reg ack", 32'(reg_ack), 32'(v.e_ack));
      chk(reg_nxm == v.e_flag, int'(v.rq), "reg nxm", 32'(reg_nxm), 32'(v.e_flag));
      if (v.e_ack)
        chk(reg_rdata == v.e_val, int'(v.rq), "reg rdata", reg_rdata, v.e_val);
    end
  endtask

  initial begin
    #4_000_000;
    nfail++;
    nchk++;
    $display("FAIL R13 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: outputs quiet under reset
    chk(reg_ack == 0 && xl_ack == 0 && xl_hit == 0, 12, "reset outputs",
        {29'b0, reg_ack, xl_ack, xl_hit}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R13: single-cycle pulses
    @(negedge clk);
    chk(reg_ack == 0 && xl_ack == 0, 13, "pulse width",
        {30'b0, reg_ack, xl_ack}, 32'h0);

    // R7: forwarding strobe is combinational
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b0; reg_size = 2'd2; reg_addr = 12'h21C;
    #1;
    chk(fwd_req == 1 && fwd_wr == 0 && fwd_idx == 3'd7, 7, "fwd read slot7",
        {27'b0, fwd_req, fwd_wr, fwd_idx}, {27'b0, 1'b1, 1'b0, 3'd7});
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h204; reg_wdata = 32'h0000_1234;
    #1;
    chk(fwd_req == 1 && fwd_wr == 1 && fwd_idx == 3'd1 && fwd_wdata == 32'h1234, 7,
        "fwd write slot1", {27'b0, fwd_req, fwd_wr, fwd_idx}, {27'b0, 1'b1, 1'b1, 3'd1});
    @(negedge clk);
    chk(reg_ack == 0, 7, "fwd no ack", 32'(reg_ack), 32'h0);
    reg_addr = 12'h21E;
    #1;
    chk(fwd_req == 0, 6, "unaligned not forwarded", 32'(fwd_req), 32'h0);
    @(negedge clk);
    idle_inputs();

    // R12: reset mid-run clears map and control word
    rst_n = 1'b0;
    #1;
    chk(reg_ack == 0 && xl_pa == '0, 12, "async reset outputs", 32'(xl_pa), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_vec('{1'b0,1'b0,2'd2,18'h804,32'h0,1'b1,1'b0,32'h0,4'd12});   // R12
    run_vec('{1'b0,1'b0,2'd2,18'h010,32'h0,1'b1,1'b0,32'h0,4'd12});   // R12
    run_vec('{1'b1,1'b0,2'd0,18'h00323,32'h0,1'b1,1'b0,32'h0,4'd12}); // R12

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule